// File: doc/BRIEF.md
# Task switch controller

This block keeps the bookkeeping of a hardware task switch for a small table of task descriptors held in flops. Each descriptor carries a four-bit type code, and bit 1 of that code is the busy bit. Each descriptor also carries a 16-bit back-link selector and a nested-task (NT) flag. A current-task register names the running task. A request asks for one of four kinds of switch:
- a jump to a selector,
- a call to a selector,
- an interrupt routed through a task gate,
- a nested return.

The block checks that the switch is legal. It then updates the busy bits, the NT flags, the back-links and the current-task register in one commit cycle.

Illegal requests produce a fault pulse with a cause code and change nothing. Every request, accepted or refused, ends with a one-cycle done strobe. A combinational peek port reads out any descriptor, so the surrounding logic can observe the table. Saving and restoring register contents is left to other blocks.

Top module: `tsw_ctrl`

## Requirements
- R1: After reset the current selector is 0x0000 and its NT flag is 0. Entry 0 reads type 0xB. Each other entry reads 0x9, or 0x1 if its LEGACY_MASK bit is set, or 0x2 if its INVALID_MASK bit is set. All links and NT flags read 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both high. req_ready is low on the next cycle. done is high for exactly one cycle, after the second rising edge following acceptance.
- R3: A successful jump (kind 0) does four things: it sets the target's busy bit, clears the old task's busy bit, clears the target's NT flag and makes the target current. No link changes.
- R4: A successful call (kind 1) does four things: it sets the target's busy bit and NT flag, writes the old current selector into the target's link, and makes the target current. The old task stays busy.
- R5: An interrupt (kind 2) with vector v below NUM_GATES reads a gate of type 0x5 that holds the selector for index v+1. It then behaves as a call to that selector. A vector of NUM_GATES or more faults with cause 4.
- R6: A return (kind 3) from a task whose NT is 1 makes that task's link current. It clears the departing task's busy bit and NT flag. The returned-to task stays busy.
- R7: A jump, call or interrupt whose target has busy bit 1 faults with cause 3. This includes the current task.
- R8: A selector uses bits 15..3 as the index, bit 2 as the table indicator and bits 1..0 as the RPL. Indicator 1, or an index of NUM_TASKS or more, faults with cause 1. A good selector becomes current with its RPL bits intact.
- R9: A target whose type is not 0x1, 0x3, 0x9 or 0xB faults with cause 2. A 16-bit entry goes from 0x1 to 0x3 when entered.
- R10: A return while the current NT is 0 faults with cause 5.
- R11: A fault raises fault together with done and leaves every descriptor and the current selector unchanged. The cause is nonzero on a fault and 0 otherwise. The first matching check wins, in this order: missing gate or NT=0, then bad selector, then bad type, then busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 jump, 1 call, 2 interrupt via gate, 3 return |
| req_sel | input | 16 | Target selector for jump and call |
| req_vec | input | VEC_W | Interrupt vector for kind 2 |
| req_ready | output | 1 | Controller idle and out of reset |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Request refused, high with done |
| fault_cause | output | 3 | Refusal cause code |
| cur_sel | output | 16 | Current task selector |
| cur_nt | output | 1 | NT flag of the current task |
| peek_idx | input | IDX_W | Descriptor index to observe |
| peek_type | output | 4 | Type code of the peeked entry |
| peek_link | output | 16 | Link selector of the peeked entry |
| peek_nt | output | 1 | NT flag of the peeked entry |

## Verification
A wrong busy bit appears on the peek port in the cycle done rises. From then on, every later jump or call to that entry gives the wrong fault verdict. A corrupted link or NT flag stays hidden until a return is issued from that task. At that point cur_sel lands on the wrong task, or a cause 5 fault appears, in the done cycle of that return. For this reason the stimulus mixes long call chains with their unwinding returns, and it compares the whole table after every request.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [1:0] {
    KIND_JUMP   = 2'd0,
    KIND_CALL   = 2'd1,
    KIND_GATE   = 2'd2,
    KIND_RETURN = 2'd3
  } tsw_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_SEL    = 3'd1,
    CAUSE_TYPE   = 3'd2,
    CAUSE_BUSY   = 3'd3,
    CAUSE_GATE   = 3'd4,
    CAUSE_NONEST = 3'd5,
    CAUSE_IDLE   = 3'd6
  } tsw_cause_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } tsw_state_e;

  localparam int SEL_W    = 16;
  localparam int IDX_LSB  = 3;
  localparam int TYPE_W   = 4;
  localparam int BUSY_BIT = 1;

  localparam logic [TYPE_W-1:0] TYPE_GATE        = 4'h5;
  localparam logic [TYPE_W-1:0] TYPE_WIDE_FREE   = 4'h9;
  localparam logic [TYPE_W-1:0] TYPE_NARROW_FREE = 4'h1;
  localparam logic [TYPE_W-1:0] TYPE_NOT_TASK    = 4'h2;

  function automatic logic is_task_type(logic [TYPE_W-1:0] t);
    return (t == 4'h1) || (t == 4'h3) || (t == 4'h9) || (t == 4'hB);
  endfunction

endpackage

// File: rtl/tsw_table.sv
module tsw_table
  import tsw_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter logic [NUM_TASKS-1:0] INVALID_MASK = '0,
  parameter logic [NUM_TASKS-1:0] LEGACY_MASK  = '0,
  parameter int IDX_W = $clog2(NUM_TASKS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              set_en,
  input  logic [IDX_W-1:0]                  set_idx,
  input  logic                              clr_en,
  input  logic [IDX_W-1:0]                  clr_idx,
  input  logic                              nt_en,
  input  logic [IDX_W-1:0]                  nt_idx,
  input  logic                              nt_val,
  input  logic                              link_en,
  input  logic [IDX_W-1:0]                  link_idx,
  input  logic [SEL_W-1:0]                  link_val,
  output logic [NUM_TASKS-1:0][TYPE_W-1:0]  types_o,
  output logic [NUM_TASKS-1:0][SEL_W-1:0]   links_o,
  output logic [NUM_TASKS-1:0]              nts_o
);

  for (genvar gi = 0; gi < NUM_TASKS; gi++) begin : g_entry
    localparam logic [TYPE_W-1:0] BASE_TYPE =
      INVALID_MASK[gi] ? TYPE_NOT_TASK :
      (LEGACY_MASK[gi] ? TYPE_NARROW_FREE : TYPE_WIDE_FREE);
    localparam logic [TYPE_W-1:0] RST_TYPE =
      (gi == 0) ? (BASE_TYPE | 4'h2) : BASE_TYPE;

    logic [TYPE_W-1:0] type_q, type_d;
    logic [SEL_W-1:0]  link_q, link_d;
    logic              nt_q, nt_d;
    logic              hit_set, hit_clr, hit_nt, hit_link, entry_en;

    assign hit_set  = set_en  && (set_idx  == IDX_W'(gi));
    assign hit_clr  = clr_en  && (clr_idx  == IDX_W'(gi));
    assign hit_nt   = nt_en   && (nt_idx   == IDX_W'(gi));
    assign hit_link = link_en && (link_idx == IDX_W'(gi));
    assign entry_en = hit_set || hit_clr || hit_nt || hit_link;

    always_comb begin
      type_d = type_q;
      link_d = link_q;
      nt_d   = nt_q;
      if (hit_set)  type_d[BUSY_BIT] = 1'b1;
      if (hit_clr)  type_d[BUSY_BIT] = 1'b0;
      if (hit_nt)   nt_d             = nt_val;
      if (hit_link) link_d           = link_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        type_q <= RST_TYPE;
        link_q <= '0;
        nt_q   <= 1'b0;
      end else if (entry_en) begin
        type_q <= type_d;
        link_q <= link_d;
        nt_q   <= nt_d;
      end
    end

    assign types_o[gi] = type_q;
    assign links_o[gi] = link_q;
    assign nts_o[gi]   = nt_q;
  end

endmodule

// File: rtl/tsw_gate_rom.sv
module tsw_gate_rom
  import tsw_pkg::*;
#(
  parameter int NUM_GATES = 4,
  parameter int VEC_W     = 3
) (
  input  logic [VEC_W-1:0]  vec,
  output logic [TYPE_W-1:0] gate_type,
  output logic [SEL_W-1:0]  gate_sel
);

  logic [NUM_GATES-1:0][SEL_W-1:0] sel_tab;

  for (genvar gv = 0; gv < NUM_GATES; gv++) begin : g_gate
    assign sel_tab[gv] = {13'(gv + 1), 1'b0, 2'b00};
  end

  always_comb begin
    gate_type = '0;
    gate_sel  = '0;
    for (int v = 0; v < NUM_GATES; v++) begin
      if (32'(vec) == v) begin
        gate_type = TYPE_GATE;
        gate_sel  = sel_tab[v];
      end
    end
  end

endmodule

// File: rtl/tsw_check.sv
module tsw_check
  import tsw_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int IDX_W = $clog2(NUM_TASKS)
) (
  input  tsw_kind_e                         kind,
  input  logic [SEL_W-1:0]                  req_sel,
  input  logic [TYPE_W-1:0]                 gate_type,
  input  logic [SEL_W-1:0]                  gate_sel,
  input  logic [IDX_W-1:0]                  cur_idx,
  input  logic [NUM_TASKS-1:0][TYPE_W-1:0]  types,
  input  logic [NUM_TASKS-1:0][SEL_W-1:0]   links,
  input  logic [NUM_TASKS-1:0]              nts,
  output logic [SEL_W-1:0]                  tgt_sel,
  output logic [IDX_W-1:0]                  tgt_idx,
  output logic                              ok,
  output tsw_cause_e                        cause
);

  logic              in_range;
  logic [TYPE_W-1:0] tgt_type;

  always_comb begin
    unique case (kind)
      KIND_GATE:   tgt_sel = gate_sel;
      KIND_RETURN: tgt_sel = links[cur_idx];
      default:     tgt_sel = req_sel;
    endcase
  end

  assign tgt_idx  = tgt_sel[IDX_LSB +: IDX_W];
  assign in_range = !tgt_sel[2] && (tgt_sel[SEL_W-1:IDX_LSB] < 13'(NUM_TASKS));
  assign tgt_type = in_range ? types[tgt_idx] : '0;

  always_comb begin
    if (kind == KIND_GATE && gate_type != TYPE_GATE)
      cause = CAUSE_GATE;
    else if (kind == KIND_RETURN && !nts[cur_idx])
      cause = CAUSE_NONEST;
    else if (!in_range)
      cause = CAUSE_SEL;
    else if (!is_task_type(tgt_type))
      cause = CAUSE_TYPE;
    else if (kind == KIND_RETURN)
      cause = tgt_type[BUSY_BIT] ? CAUSE_NONE : CAUSE_IDLE;
    else
      cause = tgt_type[BUSY_BIT] ? CAUSE_BUSY : CAUSE_NONE;
  end

  assign ok = (cause == CAUSE_NONE);

endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int NUM_GATES = 4,
  parameter int VEC_W     = 3,
  parameter logic [NUM_TASKS-1:0] INVALID_MASK = 8'h80,
  parameter logic [NUM_TASKS-1:0] LEGACY_MASK  = 8'h40,
  parameter int IDX_W = $clog2(NUM_TASKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [15:0]       req_sel,
  input  logic [VEC_W-1:0]  req_vec,
  output logic              req_ready,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_cause,
  output logic [15:0]       cur_sel,
  output logic              cur_nt,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic [3:0]        peek_type,
  output logic [15:0]       peek_link,
  output logic              peek_nt
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // sequencer state
  tsw_state_e        state_q, state_d;
  tsw_kind_e         kind_q, kind_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [SEL_W-1:0]  cur_q, cur_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;
  tsw_cause_e        cause_q, cause_d;
  logic              accept, req_en, cur_en;

  // table and decode wiring
  logic [NUM_TASKS-1:0][TYPE_W-1:0] types;
  logic [NUM_TASKS-1:0][SEL_W-1:0]  links;
  logic [NUM_TASKS-1:0]             nts;
  logic [NUM_TASKS-1:0]             busy_vec;
  logic [TYPE_W-1:0]                gate_type;
  logic [SEL_W-1:0]                 gate_sel;
  logic [SEL_W-1:0]                 tgt_sel;
  logic [IDX_W-1:0]                 tgt_idx, cur_idx;
  logic                             chk_ok;
  tsw_cause_e                       chk_cause;
  logic                             commit, is_jump, is_nest, is_ret;
  logic                             set_en, clr_en, nt_en, nt_val, link_en;
  logic [IDX_W-1:0]                 set_idx, clr_idx, nt_idx;

  assign cur_idx   = cur_q[IDX_LSB +: IDX_W];
  assign req_ready = (state_q == ST_IDLE) && rst_int_n;
  assign accept    = req_valid && req_ready;

  for (genvar gb = 0; gb < NUM_TASKS; gb++) begin : g_busy
    assign busy_vec[gb] = types[gb][BUSY_BIT];
  end

  tsw_gate_rom #(
    .NUM_GATES (NUM_GATES),
    .VEC_W     (VEC_W)
  ) u_gate (
    .vec       (vec_q),
    .gate_type (gate_type),
    .gate_sel  (gate_sel)
  );

  tsw_check #(
    .NUM_TASKS (NUM_TASKS),
    .IDX_W     (IDX_W)
  ) u_check (
    .kind      (kind_q),
    .req_sel   (sel_q),
    .gate_type (gate_type),
    .gate_sel  (gate_sel),
    .cur_idx   (cur_idx),
    .types     (types),
    .links     (links),
    .nts       (nts),
    .tgt_sel   (tgt_sel),
    .tgt_idx   (tgt_idx),
    .ok        (chk_ok),
    .cause     (chk_cause)
  );

  // commit decode
  assign commit  = (state_q == ST_EXEC) && chk_ok;
  assign is_jump = (kind_q == KIND_JUMP);
  assign is_nest = (kind_q == KIND_CALL) || (kind_q == KIND_GATE);
  assign is_ret  = (kind_q == KIND_RETURN);

  assign set_en  = commit && !is_ret;
  assign set_idx = tgt_idx;
  assign clr_en  = commit && (is_jump || is_ret);
  assign clr_idx = cur_idx;
  assign nt_en   = commit;
  assign nt_idx  = is_ret ? cur_idx : tgt_idx;
  assign nt_val  = is_nest;
  assign link_en = commit && is_nest;

  tsw_table #(
    .NUM_TASKS    (NUM_TASKS),
    .INVALID_MASK (INVALID_MASK),
    .LEGACY_MASK  (LEGACY_MASK),
    .IDX_W        (IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_en   (set_en),
    .set_idx  (set_idx),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .nt_en    (nt_en),
    .nt_idx   (nt_idx),
    .nt_val   (nt_val),
    .link_en  (link_en),
    .link_idx (tgt_idx),
    .link_val (cur_q),
    .types_o  (types),
    .links_o  (links),
    .nts_o    (nts)
  );

  // next state
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    sel_d   = sel_q;
    vec_d   = vec_q;
    cur_d   = cur_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    cause_d = CAUSE_NONE;
    req_en  = 1'b0;
    cur_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          req_en  = 1'b1;
          kind_d  = tsw_kind_e'(req_kind);
          sel_d   = req_sel;
          vec_d   = req_vec;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        fault_d = !chk_ok;
        cause_d = chk_cause;
        if (chk_ok) begin
          cur_en = 1'b1;
          cur_d  = tgt_sel;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      kind_q <= KIND_JUMP;
      sel_q  <= '0;
      vec_q  <= '0;
    end else if (req_en) begin
      kind_q <= kind_d;
      sel_q  <= sel_d;
      vec_q  <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  // outputs
  assign done        = done_q;
  assign fault       = fault_q;
  assign fault_cause = cause_q;
  assign cur_sel     = cur_q;
  assign cur_nt      = nts[cur_idx];

  always_comb begin
    if (32'(peek_idx) < NUM_TASKS) begin
      peek_type = types[peek_idx];
      peek_link = links[peek_idx];
      peek_nt   = nts[peek_idx];
    end else begin
      peek_type = '0;
      peek_link = '0;
      peek_nt   = 1'b0;
    end
  end

endmodule

// File: rtl/tsw_chk.sv
module tsw_chk
  import tsw_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int IDX_W = $clog2(NUM_TASKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 done,
  input logic                 fault,
  input logic [2:0]           fault_cause,
  input logic [15:0]          cur_sel,
  input logic                 cur_nt,
  input logic [IDX_W-1:0]     cur_idx,
  input logic [NUM_TASKS-1:0] busy_vec,
  input tsw_kind_e            kind_q
);

  // R2
  accept_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ##2 done);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  // R11
  cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((fault_cause != 3'd0) == fault));

  // R11
  fault_holds_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (cur_sel == $past(cur_sel)));

  // R3
  jump_nt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && kind_q == KIND_JUMP) |-> !cur_nt);

  // R4
  nest_nt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && (kind_q == KIND_CALL || kind_q == KIND_GATE)) |-> cur_nt);

  // R7
  cur_task_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_vec[cur_idx]);

endmodule

bind tsw_ctrl tsw_chk #(
  .NUM_TASKS (NUM_TASKS),
  .IDX_W     (IDX_W)
) u_tsw_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .fault       (fault),
  .fault_cause (fault_cause),
  .cur_sel     (cur_sel),
  .cur_nt      (cur_nt),
  .cur_idx     (cur_idx),
  .busy_vec    (busy_vec),
  .kind_q      (kind_q)
);

// File: tb/test_tsw_ctrl.sv
module test_tsw_ctrl;

  localparam int N  = 8;
  localparam int VW = 3;
  localparam int NG = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [15:0]   req_sel;
  logic [VW-1:0] req_vec;
  logic          req_ready, done, fault, cur_nt, peek_nt;
  logic [2:0]    fault_cause;
  logic [15:0]   cur_sel, peek_link;
  logic [IW-1:0] peek_idx;
  logic [3:0]    peek_type;

  always #10 clk = ~clk;

  tsw_ctrl i_tsw_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_sel(req_sel), .req_vec(req_vec), .req_ready(req_ready), .done(done),
    .fault(fault), .fault_cause(fault_cause), .cur_sel(cur_sel), .cur_nt(cur_nt),
    .peek_idx(peek_idx), .peek_type(peek_type), .peek_link(peek_link),
    .peek_nt(peek_nt)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [3:0]  m_type [N];
  logic [15:0] m_link [N];
  logic        m_nt   [N];
  logic [15:0] m_cur;

  function automatic logic [15:0] S(int idx);
    return {13'(idx), 3'b000};
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_type[i] = (i == 7) ? 4'h2 : ((i == 6) ? 4'h1 : 4'h9);
      m_link[i] = '0;
      m_nt[i]   = 1'b0;
    end
    m_type[0] = 4'hB;
    m_cur     = '0;
  endfunction

  // expected cause; applies the switch to the model when legal
  function automatic logic [2:0] model_step(logic [1:0] kind, logic [15:0] sel,
                                            logic [VW-1:0] vec);
    logic [15:0] s;
    int ci, ti;
    ci = int'(m_cur[15:3]);
    if (kind == 2'd2) begin
      if (int'(vec) >= NG) return 3'd4;
      s = S(int'(vec) + 1);
    end else if (kind == 2'd3) begin
      if (!m_nt[ci]) return 3'd5;
      s = m_link[ci];
    end else begin
      s = sel;
    end
    if (s[2] || int'(s[15:3]) >= N) return 3'd1;
    ti = int'(s[15:3]);
    if (!(m_type[ti] inside {4'h1, 4'h3, 4'h9, 4'hB})) return 3'd2;
    if (kind == 2'd3) begin
      if (!m_type[ti][1]) return 3'd6;
      m_type[ci][1] = 1'b0;
      m_nt[ci]      = 1'b0;
      m_cur         = s;
      return 3'd0;
    end
    if (m_type[ti][1]) return 3'd3;
    m_type[ti][1] = 1'b1;
    if (kind == 2'd0) begin
      m_type[ci][1] = 1'b0;
      m_nt[ti]      = 1'b0;
    end else begin
      m_nt[ti]   = 1'b1;
      m_link[ti] = m_cur;
    end
    m_cur = s;
    return 3'd0;
  endfunction

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check_eq(req, "cur_sel", 32'(cur_sel), 32'(m_cur));
    check_eq(req, "cur_nt", 32'(cur_nt), 32'(m_nt[int'(m_cur[15:3])]));
    for (int i = 0; i < N; i++) begin
      peek_idx = IW'(i);
      #1;
      check_eq(req, $sformatf("entry %0d", i),
               {11'd0, peek_type, peek_link, peek_nt},
               {11'd0, m_type[i], m_link[i], m_nt[i]});
    end
  endtask

  task automatic do_req(logic [1:0] kind, logic [15:0] sel, logic [VW-1:0] vec,
                        string req);
    logic [2:0] exp;
    exp = model_step(kind, sel, vec);
    @(negedge clk);
    check_eq("R2", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_kind  = kind;
    req_sel   = sel;
    req_vec   = vec;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R2", "done early", 32'(done), 32'd0);
    check_eq("R2", "ready while busy", 32'(req_ready), 32'd0);
    @(negedge clk);
    check_eq("R2", "done strobe", 32'(done), 32'd1);
    check_eq(req, "fault", 32'(fault), 32'(exp != 3'd0));
    check_eq(req, "cause", 32'(fault_cause), 32'(exp));
    check_state(req);
    @(negedge clk);
    check_eq("R2", "done drops", 32'(done), 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  string kind_tag [4] = '{"R3", "R4", "R5", "R6"};

  initial begin
    void'($urandom(32'd20151218));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_kind  = '0;
    req_sel   = '0;
    req_vec   = '0;
    peek_idx  = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset contents
    check_eq("R1", "done after reset", 32'(done), 32'd0);
    check_state("R1");

    // nested calls 0 -> 1 -> 2 -> 3
    do_req(2'd1, S(1), '0, "R4");
    do_req(2'd1, S(2), '0, "R4");
    do_req(2'd1, S(3), '0, "R4");
    // re-entry refused
    do_req(2'd1, S(1), '0, "R7/R11");
    do_req(2'd0, S(2), '0, "R7/R11");
    do_req(2'd1, S(3), '0, "R7/R11");
    // unwind
    do_req(2'd3, '0, '0, "R6");
    do_req(2'd3, '0, '0, "R6");
    do_req(2'd3, '0, '0, "R6");
    do_req(2'd3, '0, '0, "R10/R11");
    // jumps
    do_req(2'd0, S(4), '0, "R3");
    do_req(2'd3, '0, '0, "R10");
    do_req(2'd0, S(0), '0, "R3");
    // type checks and 16-bit entry
    do_req(2'd1, S(7), '0, "R9/R11");
    do_req(2'd1, S(6), '0, "R9");
    do_req(2'd3, '0, '0, "R6");
    // selector format
    do_req(2'd0, S(1) | 16'h0004, '0, "R8/R11");
    do_req(2'd1, S(9), '0, "R8/R11");
    do_req(2'd1, S(1) | 16'h0003, '0, "R8");
    do_req(2'd3, '0, '0, "R6");
    // gates
    do_req(2'd2, '0, 3'd1, "R5");
    do_req(2'd2, '0, 3'd5, "R5/R11");
    do_req(2'd2, '0, 3'd3, "R5");
    do_req(2'd3, '0, '0, "R6");
    do_req(2'd3, '0, '0, "R6");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [1:0]  kd;
      logic [15:0] sl;
      kd = 2'($urandom_range(0, 3));
      sl = {13'($urandom_range(0, 9)), ($urandom_range(0, 7) == 0),
            2'($urandom_range(0, 3))};
      do_req(kd, sl, VW'($urandom_range(0, 5)), kind_tag[kd]);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule